// File: doc/BRIEF.md
# Serial-Loaded DAC Input Interface

This block is the digital front end of a 16-bit multiplying DAC. A host shifts a code word into an input shift register one bit per strobe edge, most significant bit first, then pulls two load pins low together to copy that word into the parallel holding register that drives the converter. There are four strobe pins. Three of them shift on a rising edge and one shifts on a falling edge. A strobe edge counts only while the other three strobes are at their idle levels, so any one strobe can act as the serial clock and the others can gate it.

The bit pushed out of the top of the shift register goes to a chain output, so several converters can share one serial line. The chain output shows the previous word, MSB first, while the new word is shifted in. An active-low clear pin, and the block reset, put both registers at a value chosen at build time: zero scale for unipolar use, or midscale for bipolar use. All pins are sampled on a fast system clock, and strobe edges are found on that clock.

Top module: `serdac_front`

## Requirements
- R1: The input register is 16 bits wide and fills MSB first. After 16 accepted strobe edges and a load, `dac_word` equals the word that was sent, with the first bit sent in bit 15.
- R2: `stb_a`, `stb_b` and `stb_d` shift on a rising edge, and `stb_c_n` shifts on a falling edge. Each of the four can shift a complete word on its own.
- R3: A strobe edge shifts only while the other three strobes are idle (low for `stb_a`, `stb_b`, `stb_d`; high for `stb_c_n`). Edges on two strobes in the same sample also cause no shift. A gated edge changes neither the input register nor `chain_out`.
- R4: The holding register copies the input register on every system clock while both `ld_a_n` and `ld_b_n` are low. If either of them is high, `dac_word` holds its value.
- R5: While `clr_n` is low, both registers and `chain_out` are reset, even when both load pins are low. A clear in the middle of a word leaves the reset value in the input register.
- R6: With parameter `CLR_MID` = 0 the reset value is 0x0000. With `CLR_MID` = 1 it is 0x8000.
- R7: On each accepted strobe edge, `chain_out` takes the bit that leaves bit 15 of the input register. While a new word is shifted in, `chain_out` therefore shows the previous word, MSB first.
- R8: After `rst_n` is released, `dac_word` holds the reset value of R6 and `chain_out` is 0.
- R9: Load pins may go low in the same instant as the strobe edge that shifts the LSB, and `dac_word` still ends up with the complete new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must run at least 4x the strobe rate |
| rst_n | input | 1 | Asynchronous active-low block reset |
| sdi | input | 1 | Serial data in |
| stb_a | input | 1 | Strobe, rising edge active |
| stb_b | input | 1 | Strobe, rising edge active |
| stb_c_n | input | 1 | Strobe, falling edge active |
| stb_d | input | 1 | Strobe, rising edge active |
| ld_a_n | input | 1 | Load enable, active low |
| ld_b_n | input | 1 | Load enable, active low |
| clr_n | input | 1 | Clear, active low |
| dac_word | output | 16 | Holding register value for the converter |
| chain_out | output | 1 | Daisy-chain serial output |

## Verification
The bench sends two words back to back through different strobes and checks every chain output bit against the first word. A design whose shifted-out bit is off by one position, or that is taken from the wrong end, fails here. It drives edges while another strobe sits at its active level, and edges on two strobes at once. A design that does not gate these would change the input register, and then the following load and the chain output would show it. It pulls one load pin low at a time, which catches a design that combines the two with an OR. It clears in the middle of a word while an instance built for midscale runs alongside, which catches a wrong clear value or an input register that is not cleared. Finally it lowers both load pins together with the last strobe edge, which catches a design that latches the word before the final bit arrives.

// File: rtl/dfe_pkg.sv
package dfe_pkg;

  localparam int DFE_NUM_STB = 4;
  // strobe index 2 is the falling-edge one; the rest are rising
  localparam logic [DFE_NUM_STB-1:0] DFE_STB_IDLE = 4'b0100;

  typedef struct packed {
    logic                   sdi;
    logic                   clr_n;
    logic                   ld_b_n;
    logic                   ld_a_n;
    logic [DFE_NUM_STB-1:0] stb;
  } dfe_pins_t;

  localparam dfe_pins_t DFE_PINS_IDLE = '{
    sdi:    1'b0,
    clr_n:  1'b1,
    ld_b_n: 1'b1,
    ld_a_n: 1'b1,
    stb:    DFE_STB_IDLE
  };

endpackage

// File: rtl/dfe_sync.sv
module dfe_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  always_comb begin
    stg_d[0] = d;
    for (int i = 1; i < STAGES; i++) begin
      stg_d[i] = stg_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= {STAGES{RST_VAL}};
    end else begin
      stg_q <= stg_d;
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/dfe_strobe_dec.sv
module dfe_strobe_dec #(
  parameter int           N         = 4,
  parameter logic [N-1:0] IDLE_LVL  = 4'b0100
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic         shift_en
);

  logic [N-1:0] act_now;
  logic [N-1:0] act_prev_q;
  logic [N-1:0] fire;

  // a strobe is "active" when it is away from its idle level
  assign act_now = lvl ^ IDLE_LVL;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_prev_q <= '0;
    end else begin
      act_prev_q <= act_now;
    end
  end

  generate
    for (genvar i = 0; i < N; i++) begin : g_fire
      logic [N-1:0] others;
      always_comb begin
        others    = act_now;
        others[i] = 1'b0;
      end
      assign fire[i] = act_now[i] & ~act_prev_q[i] & ~(|others);
    end
  endgenerate

  assign shift_en = |fire;

endmodule

// File: rtl/dfe_shift_reg.sv
module dfe_shift_reg #(
  parameter int           W       = 16,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] word,
  output logic         chain
);

  logic [W-1:0] word_q, word_d;
  logic         chain_q, chain_d;

  always_comb begin
    word_d  = word_q;
    chain_d = chain_q;
    if (clr) begin
      word_d  = RST_VAL;
      chain_d = 1'b0;
    end else if (shift_en) begin
      word_d  = {word_q[W-2:0], din};
      chain_d = word_q[W-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= RST_VAL;
      chain_q <= 1'b0;
    end else begin
      word_q  <= word_d;
      chain_q <= chain_d;
    end
  end

  assign word  = word_q;
  assign chain = chain_q;

endmodule

// File: rtl/dfe_hold_reg.sv
module dfe_hold_reg #(
  parameter int           W       = 16,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load_en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] hold_q, hold_d;

  always_comb begin
    hold_d = hold_q;
    if (clr) begin
      hold_d = RST_VAL;
    end else if (load_en) begin
      hold_d = din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= RST_VAL;
    end else begin
      hold_q <= hold_d;
    end
  end

  assign dout = hold_q;

endmodule

// File: rtl/serdac_front.sv
module serdac_front #(
  parameter int   W           = 16,
  parameter bit   CLR_MID     = 1'b0,
  parameter int   SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sdi,
  input  logic         stb_a,
  input  logic         stb_b,
  input  logic         stb_c_n,
  input  logic         stb_d,
  input  logic         ld_a_n,
  input  logic         ld_b_n,
  input  logic         clr_n,
  output logic [W-1:0] dac_word,
  output logic         chain_out
);
  import dfe_pkg::*;

  localparam logic [W-1:0] RST_WORD = CLR_MID ? {1'b1, {(W-1){1'b0}}} : '0;
  localparam int           PIN_W    = $bits(dfe_pins_t);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  // sample every pin together so data stays aligned with strobes
  dfe_pins_t pins_raw, pins_s;

  always_comb begin
    pins_raw.sdi    = sdi;
    pins_raw.clr_n  = clr_n;
    pins_raw.ld_b_n = ld_b_n;
    pins_raw.ld_a_n = ld_a_n;
    pins_raw.stb    = {stb_d, stb_c_n, stb_b, stb_a};
  end

  dfe_sync #(
    .W       (PIN_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (DFE_PINS_IDLE)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     (pins_raw),
    .q     (pins_s)
  );

  logic         shift_en;
  logic         load_en;
  logic         clr_act;
  logic         sdi_s;
  logic [W-1:0] sr_word;

  assign load_en = ~pins_s.ld_a_n & ~pins_s.ld_b_n;
  assign clr_act = ~pins_s.clr_n;
  assign sdi_s   = pins_s.sdi;

  dfe_strobe_dec #(
    .N        (DFE_NUM_STB),
    .IDLE_LVL (DFE_STB_IDLE)
  ) u_dec (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .lvl      (pins_s.stb),
    .shift_en (shift_en)
  );

  dfe_shift_reg #(
    .W       (W),
    .RST_VAL (RST_WORD)
  ) u_sr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clr      (clr_act),
    .shift_en (shift_en),
    .din      (sdi_s),
    .word     (sr_word),
    .chain    (chain_out)
  );

  dfe_hold_reg #(
    .W       (W),
    .RST_VAL (RST_WORD)
  ) u_hold (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clr     (clr_act),
    .load_en (load_en),
    .din     (sr_word),
    .dout    (dac_word)
  );

endmodule

// File: rtl/serdac_front_chk.sv
module serdac_front_chk #(
  parameter int           W        = 16,
  parameter logic [W-1:0] RST_WORD = '0
) (
  input logic         clk,
  input logic         rst_sync_n,
  input logic         shift_en,
  input logic         load_en,
  input logic         clr_act,
  input logic         sdi_s,
  input logic [W-1:0] sr_word,
  input logic [W-1:0] dac_word,
  input logic         chain_out
);

  // R1: accepted edge shifts MSB-first
  a_r1_shift_in: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (shift_en && !clr_act) |=> sr_word == {$past(sr_word[W-2:0]), $past(sdi_s)});

  // R3: no accepted edge, no change to the input register or chain
  a_r3_no_stray_shift: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!shift_en && !clr_act) |=> ($stable(sr_word) && $stable(chain_out)));

  // R4: holding register copies only with both load pins low
  a_r4_load_copy: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (load_en && !clr_act) |=> dac_word == $past(sr_word));

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!load_en && !clr_act) |=> $stable(dac_word));

  // R5: clear wins over load and shift
  a_r5_clear_wins: assert property (@(posedge clk) disable iff (!rst_sync_n)
    clr_act |=> (dac_word == RST_WORD && sr_word == RST_WORD && !chain_out));

  // R7: chain output takes the bit leaving the top
  a_r7_chain_bit: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (shift_en && !clr_act) |=> chain_out == $past(sr_word[W-1]));

endmodule

bind serdac_front serdac_front_chk #(
  .W        (W),
  .RST_WORD (RST_WORD)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .shift_en   (shift_en),
  .load_en    (load_en),
  .clr_act    (clr_act),
  .sdi_s      (sdi_s),
  .sr_word    (sr_word),
  .dac_word   (dac_word),
  .chain_out  (chain_out)
);

// File: tb/serdac_front_test.sv
module serdac_front_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sdi;
  logic [3:0]  stb;      // {stb_d, stb_c_n, stb_b, stb_a}
  logic        ld_a_n, ld_b_n, clr_n;
  logic [15:0] dac_word, dac_mid;
  logic        chain_out, chain_mid;

  always #2.5 clk = ~clk;   // 200 MHz

  serdac_front #(.CLR_MID(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .sdi(sdi),
    .stb_a(stb[0]), .stb_b(stb[1]), .stb_c_n(stb[2]), .stb_d(stb[3]),
    .ld_a_n(ld_a_n), .ld_b_n(ld_b_n), .clr_n(clr_n),
    .dac_word(dac_word), .chain_out(chain_out)
  );

  serdac_front #(.CLR_MID(1'b1)) uut_mid (
    .clk(clk), .rst_n(rst_n), .sdi(sdi),
    .stb_a(stb[0]), .stb_b(stb[1]), .stb_c_n(stb[2]), .stb_d(stb[3]),
    .ld_a_n(ld_a_n), .ld_b_n(ld_b_n), .clr_n(clr_n),
    .dac_word(dac_mid), .chain_out(chain_mid)
  );

  typedef struct {
    string       req;
    int          sel;   // 0 dac_word, 1 chain_out, 2 midscale dac, 3 midscale chain
    logic [15:0] exp;
  } item_t;

  item_t q[$];
  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 1'b0;

  // monitor: pop and compare away from the active edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [15:0] got;
      it = q.pop_front();
      case (it.sel)
        0:       got = dac_word;
        1:       got = {15'b0, chain_out};
        2:       got = dac_mid;
        default: got = {15'b0, chain_mid};
      endcase
      n_tests++;
      if (got !== it.exp) begin
        n_fail++;
        $display("FAIL %s: got %h expected %h", it.req, got, it.exp);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_val(string req, int sel, logic [15:0] exp);
    q.push_back('{req, sel, exp});
    @(negedge clk);
    #1;
  endtask

  // one accepted edge on strobe idx: leave idle, hold, return to idle
  task automatic strobe(int idx, logic bit_v);
    sdi = bit_v;
    tick(3);
    stb[idx] = ~stb[idx];
    tick(6);
    stb[idx] = ~stb[idx];
    tick(6);
  endtask

  task automatic send_word(int idx_a, int idx_b, logic [15:0] w,
                           bit chk_chain, logic [15:0] prev);
    for (int k = 15; k >= 0; k--) begin
      strobe((k % 2 == 1) ? idx_a : idx_b, w[k]);
      if (chk_chain) expect_val("R7", 1, {15'b0, prev[k]});
    end
  endtask

  task automatic load_both();
    ld_a_n = 1'b0; ld_b_n = 1'b0;
    tick(6);
    ld_a_n = 1'b1; ld_b_n = 1'b1;
    tick(6);
  endtask

  localparam logic [15:0] WA = 16'hA5C3;
  localparam logic [15:0] WB = 16'h3C96;
  localparam logic [15:0] WC = 16'h7E01;
  localparam logic [15:0] WD = 16'hC35B;

  initial begin
    rst_n = 1'b0; sdi = 1'b0; stb = 4'b0100;
    ld_a_n = 1'b1; ld_b_n = 1'b1; clr_n = 1'b1;
    tick(5);
    rst_n = 1'b1;
    tick(6);

    // R8 / R6: reset values
    expect_val("R8", 0, 16'h0000);
    expect_val("R8", 1, 16'h0000);
    expect_val("R6", 2, 16'h8000);

    // R1: word A through stb_a, loads high so R4 hold first
    send_word(0, 0, WA, 1'b0, 16'h0);
    expect_val("R4", 0, 16'h0000);
    load_both();
    expect_val("R1", 0, WA);

    // R2 / R7: word B through the falling strobe, chain shows A
    send_word(2, 2, WB, 1'b1, WA);
    expect_val("R4", 0, WA);
    ld_a_n = 1'b0; tick(6);
    expect_val("R4", 0, WA);
    ld_a_n = 1'b1; ld_b_n = 1'b0; tick(6);
    expect_val("R4", 0, WA);
    ld_b_n = 1'b1; tick(4);
    load_both();
    expect_val("R2", 0, WB);

    // R3: simultaneous edges, and edges while another strobe is active
    sdi = 1'b1; tick(3);
    stb[0] = 1'b1; stb[1] = 1'b1; tick(6);
    stb[2] = 1'b0; tick(6); stb[2] = 1'b1; tick(6);
    stb[0] = 1'b0; stb[1] = 1'b0; tick(6);
    stb[2] = 1'b0; stb[3] = 1'b1; tick(6);
    stb[0] = 1'b1; tick(6); stb[0] = 1'b0; tick(6);
    stb[2] = 1'b1; stb[3] = 1'b0; tick(6);
    expect_val("R3", 1, {15'b0, WA[0]});
    load_both();
    expect_val("R3", 0, WB);

    // R2 / R7: word C alternating stb_b and stb_d
    send_word(1, 3, WC, 1'b1, WB);
    load_both();
    expect_val("R2", 0, WC);

    // R9: load pins fall together with the LSB strobe edge
    for (int k = 15; k >= 1; k--) strobe(0, WD[k]);
    sdi = WD[0]; tick(3);
    stb[0] = 1'b1; ld_a_n = 1'b0; ld_b_n = 1'b0;
    tick(6);
    expect_val("R9", 0, WD);
    stb[0] = 1'b0; ld_a_n = 1'b1; ld_b_n = 1'b1;
    tick(6);

    // R5 / R6: clear in the middle of a word, loads high
    for (int k = 15; k >= 11; k--) strobe(3, WA[k]);
    clr_n = 1'b0; tick(6);
    expect_val("R5", 0, 16'h0000);
    expect_val("R5", 1, 16'h0000);
    expect_val("R6", 2, 16'h8000);
    expect_val("R5", 3, 16'h0000);
    // clear held while both loads low still wins
    ld_a_n = 1'b0; ld_b_n = 1'b0; tick(6);
    expect_val("R5", 0, 16'h0000);
    clr_n = 1'b1; tick(6);
    expect_val("R5", 0, 16'h0000);
    expect_val("R6", 2, 16'h8000);
    ld_a_n = 1'b1; ld_b_n = 1'b1;
    tick(6);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule